// File: doc/BRIEF.md
# Programmable 32-Line GPIO Port Controller

This block controls 32 general-purpose I/O lines from a simple word-addressed register bus. Each line carries a set of one-bit attributes: ownership, output enable, output value, pull-up, open-drain, filter enable, filter kind, peripheral choice, interrupt enable and interrupt mode. Software changes an attribute with a write to its set word or to its clear word, and reads it back through its status word. A line owned by the port drives its own output value and enable. A line given away is driven by peripheral function A or peripheral function B.

On the input side every pin passes through a two-flop synchronizer. An optional per-line filter follows. It is either a one-clock glitch rejecter or a debouncer clocked by a programmable slow tick. The filtered levels feed the peripherals and the interrupt logic. Interrupt events are latched in a status word that clears when it is read. A single interrupt output is raised while any pending line is also enabled. A masked write word updates several output values in one access.

Top module: `gpio_port`

## Requirements
- R1: Attribute k (0..12) has its set word at address 4k, its clear word at 4k+1 and its status word at 4k+2. Ones written to the set word raise the matching bits and ones written to the clear word lower them. Zero bits leave lines unchanged. Attribute order: 0 ownership, 1 output enable, 2 output value, 3 pull-up, 4 open-drain, 5 filter enable, 6 filter kind (1 = debounce), 7 peripheral choice (1 = B), 8 interrupt enable, 9 interrupt special mode, 10 interrupt level mode, 11 interrupt polarity, 12 synchronous-write mask.
- R2: After reset the ownership status reads all ones and every other attribute reads zero. Also after reset, `pad_oe` is zero and `irq` is low.
- R3: A line with ownership 1 drives the output value and output enable attributes. With ownership 0 it drives `pa_out`/`pa_oe` when the peripheral choice is 0, and `pb_out`/`pb_oe` when it is 1.
- R4: On an open-drain line `pad_out` is 0 and `pad_oe` is high only while the selected source enables the line and drives it low.
- R5: `pad_pullup` equals the pull-up attribute.
- R6: Address 0x40 returns every pin level two clocks after it is applied, whatever the line's ownership.
- R7: With the filter enabled and filter kind 0, an input pulse one clock long is rejected. A pulse two clocks long reaches `per_in` and the interrupt logic.
- R8: With filter kind 1, a level reaches `per_in` only after it has stayed stable for 3 slow ticks. A slow tick occurs every DIV+1 clocks, and DIV is read and written at address 0x43.
- R9: The interrupt mode is chosen per line. Special mode 0 means any change. Special 1 with level 0 means a rising edge when polarity is 1 and a falling edge when it is 0. Special 1 with level 1 means high level when polarity is 1 and low level when it is 0.
- R10: Address 0x41 returns the latched events and clears them on read. An event that arrives in the same cycle as the read stays pending.
- R11: `irq` is high exactly when some line is both pending and interrupt-enabled.
- R12: A write to address 0x42 copies the written bits into the output value only where the synchronous-write mask is 1. Reading 0x42 returns the output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears event status at 0x41) |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| pin_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pullup | output | 32 | Pull-up enables |
| pa_out | input | 32 | Peripheral A output values |
| pa_oe | input | 32 | Peripheral A output enables |
| pb_out | input | 32 | Peripheral B output values |
| pb_oe | input | 32 | Peripheral B output enables |
| per_in | output | 32 | Synchronized and filtered input levels |
| irq | output | 1 | Interrupt request |

## Verification
A read of the event status word and a new input event can fall on the same clock edge. The clear-on-read must then drop only the events already reported and keep the new one. The bench provokes this by toggling a pin exactly two edges before the read strobe, so that the synchronized edge is detected in the read cycle itself. It then judges that the read data omits the new line, that a second read shows it, and that the line reported by the first read has gone. The mode sweep and the filter pulses are scored against pulse lengths and levels computed in the bench.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NL     = 32;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;

    typedef logic [NL-1:0] lines_t;

    typedef enum logic [3:0] {
        AT_OWN  = 4'd0,
        AT_OE   = 4'd1,
        AT_OUT  = 4'd2,
        AT_PU   = 4'd3,
        AT_MD   = 4'd4,
        AT_FLT  = 4'd5,
        AT_FDB  = 4'd6,
        AT_PSB  = 4'd7,
        AT_IEN  = 4'd8,
        AT_ISEL = 4'd9,
        AT_ILVL = 4'd10,
        AT_IPOL = 4'd11,
        AT_SWE  = 4'd12
    } attr_e;

    localparam int N_ATTR = 13;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_CLR = 2'd1,
        OP_STS = 2'd2
    } op_e;

    localparam logic [ADDR_W-1:0] ADR_PINS = 7'h40;
    localparam logic [ADDR_W-1:0] ADR_ISR  = 7'h41;
    localparam logic [ADDR_W-1:0] ADR_SYNC = 7'h42;
    localparam logic [ADDR_W-1:0] ADR_DIV  = 7'h43;

    typedef struct packed {
        lines_t own;
        lines_t oe;
        lines_t out;
        lines_t pu;
        lines_t md;
        lines_t flt;
        lines_t fdb;
        lines_t psb;
        lines_t ien;
        lines_t isel;
        lines_t ilvl;
        lines_t ipol;
        lines_t swe;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] attr_addr(attr_e a, op_e op);
        return {1'b0, a, op};
    endfunction

    // Per-line event: any change, edge of chosen polarity, or level.
    function automatic lines_t line_event(lines_t cur, lines_t prev, lines_t isel,
                                          lines_t ilvl, lines_t ipol);
        lines_t rise, fall, edge_ev, lvl_ev;
        rise    = cur & ~prev;
        fall    = ~cur & prev;
        edge_ev = (ipol & rise) | (~ipol & fall);
        lvl_ev  = (ipol & cur) | (~ipol & ~cur);
        return (~isel & (rise | fall)) | (isel & ~ilvl & edge_ev) | (isel & ilvl & lvl_ev);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  lines_t            pins,
    input  lines_t            isr,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div_q,
    output logic              isr_rd
);

    lines_t     attr_q [N_ATTR];
    logic [3:0] sel;
    op_e        op;
    logic       attr_space;
    logic       sync_wr;

    assign sel        = bus_addr[5:2];
    assign op         = op_e'(bus_addr[1:0]);
    assign attr_space = !bus_addr[6] && (int'(sel) < N_ATTR);
    assign sync_wr    = bus_wr && (bus_addr == ADR_SYNC);
    assign isr_rd     = bus_rd && (bus_addr == ADR_ISR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_ATTR; k++)
                attr_q[k] <= (k == int'(AT_OWN)) ? '1 : '0;
        end else begin
            for (int k = 0; k < N_ATTR; k++) begin
                if (bus_wr && attr_space && int'(sel) == k && op == OP_SET)
                    attr_q[k] <= attr_q[k] | bus_wdata;
                else if (bus_wr && attr_space && int'(sel) == k && op == OP_CLR)
                    attr_q[k] <= attr_q[k] & ~bus_wdata;
                else if (k == int'(AT_OUT) && sync_wr)
                    attr_q[k] <= (attr_q[k] & ~attr_q[AT_SWE]) | (bus_wdata & attr_q[AT_SWE]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (bus_wr && bus_addr == ADR_DIV)
            div_q <= bus_wdata[DIV_W-1:0];
    end

    assign ctrl.own  = attr_q[AT_OWN];
    assign ctrl.oe   = attr_q[AT_OE];
    assign ctrl.out  = attr_q[AT_OUT];
    assign ctrl.pu   = attr_q[AT_PU];
    assign ctrl.md   = attr_q[AT_MD];
    assign ctrl.flt  = attr_q[AT_FLT];
    assign ctrl.fdb  = attr_q[AT_FDB];
    assign ctrl.psb  = attr_q[AT_PSB];
    assign ctrl.ien  = attr_q[AT_IEN];
    assign ctrl.isel = attr_q[AT_ISEL];
    assign ctrl.ilvl = attr_q[AT_ILVL];
    assign ctrl.ipol = attr_q[AT_IPOL];
    assign ctrl.swe  = attr_q[AT_SWE];

    always_comb begin
        bus_rdata = '0;
        if (attr_space) begin
            if (op == OP_STS)
                bus_rdata = attr_q[sel];
        end else begin
            case (bus_addr)
                ADR_PINS: bus_rdata = pins;
                ADR_ISR:  bus_rdata = isr;
                ADR_SYNC: bus_rdata = attr_q[AT_OUT];
                ADR_DIV:  bus_rdata = DATA_W'(div_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter
    import gpio_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int DB_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  lines_t           pin_in,
    input  logic [DIV_W-1:0] div_q,
    input  lines_t           flt,
    input  lines_t           fdb,
    output lines_t           sync_lvl,
    output lines_t           filt_lvl
);

    localparam int DBC_W = $clog2(DB_TICKS + 1);

    lines_t meta_q, sync_q, sync_prev_q, glitch_q, deb;
    lines_t same;
    logic [DIV_W-1:0] tick_cnt;
    logic tick;

    // Two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q      <= '0;
            sync_q      <= '0;
            sync_prev_q <= '0;
            glitch_q    <= '0;
        end else begin
            meta_q      <= pin_in;
            sync_q      <= meta_q;
            sync_prev_q <= sync_q;
            glitch_q    <= (glitch_q & ~same) | (sync_q & same);
        end
    end

    // A level is accepted by the glitch stage only once seen on two samples.
    assign same = ~(sync_q ^ sync_prev_q);

    // Slow tick divider shared by all debouncers.
    assign tick = (tick_cnt >= div_q);

    always_ff @(posedge clk) begin
        if (rst)
            tick_cnt <= '0;
        else if (tick)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + 1'b1;
    end

    for (genvar i = 0; i < NL; i++) begin : g_deb
        logic [DBC_W-1:0] cnt;
        logic             lvl;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
                lvl <= 1'b0;
            end else if (sync_q[i] == lvl) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == DBC_W'(DB_TICKS - 1)) begin
                    lvl <= sync_q[i];
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign deb[i] = lvl;
    end

    assign sync_lvl = sync_q;
    assign filt_lvl = (~flt & sync_q) | (flt & ~fdb & glitch_q) | (flt & fdb & deb);

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t filt_lvl,
    input  lines_t isel,
    input  lines_t ilvl,
    input  lines_t ipol,
    input  lines_t ien,
    input  logic   isr_rd,
    output lines_t isr,
    output lines_t evt,
    output logic   irq
);

    lines_t prev_q;

    assign evt = line_event(filt_lvl, prev_q, isel, ilvl, ipol);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            isr    <= '0;
        end else begin
            prev_q <= filt_lvl;
            isr    <= (isr_rd ? '0 : isr) | evt;
        end
    end

    assign irq = |(isr & ien);

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
    import gpio_pkg::*;
(
    input  lines_t own,
    input  lines_t psb,
    input  lines_t md,
    input  lines_t gp_out,
    input  lines_t gp_oe,
    input  lines_t pa_out,
    input  lines_t pa_oe,
    input  lines_t pb_out,
    input  lines_t pb_oe,
    output lines_t pad_out,
    output lines_t pad_oe
);

    for (genvar i = 0; i < NL; i++) begin : g_line
        logic src_out, src_oe;
        assign src_out    = own[i] ? gp_out[i] : (psb[i] ? pb_out[i] : pa_out[i]);
        assign src_oe     = own[i] ? gp_oe[i]  : (psb[i] ? pb_oe[i]  : pa_oe[i]);
        assign pad_out[i] = md[i] ? 1'b0 : src_out;
        assign pad_oe[i]  = src_oe & ~(md[i] & src_out);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int DB_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NL-1:0]     pin_in,
    output logic [NL-1:0]     pad_out,
    output logic [NL-1:0]     pad_oe,
    output logic [NL-1:0]     pad_pullup,
    input  logic [NL-1:0]     pa_out,
    input  logic [NL-1:0]     pa_oe,
    input  logic [NL-1:0]     pb_out,
    input  logic [NL-1:0]     pb_oe,
    output logic [NL-1:0]     per_in,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [DIV_W-1:0] div_q;
    lines_t           sync_lvl, filt_lvl, isr, evt;
    logic             isr_rd;

    gpio_regfile #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins      (sync_lvl),
        .isr       (isr),
        .ctrl      (ctrl),
        .div_q     (div_q),
        .isr_rd    (isr_rd)
    );

    gpio_in_filter #(.DIV_W(DIV_W), .DB_TICKS(DB_TICKS)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .div_q    (div_q),
        .flt      (ctrl.flt),
        .fdb      (ctrl.fdb),
        .sync_lvl (sync_lvl),
        .filt_lvl (filt_lvl)
    );

    gpio_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .filt_lvl (filt_lvl),
        .isel     (ctrl.isel),
        .ilvl     (ctrl.ilvl),
        .ipol     (ctrl.ipol),
        .ien      (ctrl.ien),
        .isr_rd   (isr_rd),
        .isr      (isr),
        .evt      (evt),
        .irq      (irq)
    );

    gpio_out_mux u_omux (
        .own     (ctrl.own),
        .psb     (ctrl.psb),
        .md      (ctrl.md),
        .gp_out  (ctrl.out),
        .gp_oe   (ctrl.oe),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pullup = ctrl.pu;
    assign per_in     = filt_lvl;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input lines_t            oe,
    input lines_t            out,
    input lines_t            own,
    input lines_t            md,
    input lines_t            swe,
    input lines_t            pad_oe,
    input lines_t            isr,
    input lines_t            evt,
    input logic              isr_rd
);

    assert_set_raises_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == attr_addr(AT_OE, OP_SET))
        |=> ((oe & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_keeps_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == attr_addr(AT_OE, OP_CLR))
        |=> (oe == ($past(oe) & ~$past(bus_wdata))));

    assert_open_drain_high_R4: assert property (@(posedge clk) disable iff (rst)
        ((md & own & out & pad_oe) == '0));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && evt == '0) |=> (isr == '0));

    assert_event_survives_R10: assert property (@(posedge clk) disable iff (rst)
        isr_rd |=> ((isr & $past(evt)) == $past(evt)));

    assert_sync_mask_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_SYNC)
        |=> (((out ^ $past(out)) & ~$past(swe)) == '0));

endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .oe        (ctrl.oe),
    .out       (ctrl.out),
    .own       (ctrl.own),
    .md        (ctrl.md),
    .swe       (ctrl.swe),
    .pad_oe    (pad_oe),
    .isr       (isr),
    .evt       (evt),
    .isr_rd    (isr_rd)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    import gpio_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pad_out, pad_oe, pad_pullup;
    logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0, per_in;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .per_in(per_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_attr(input int k, input logic [31:0] d);
        bus_write(7'(k * 4), d);
    endtask

    task automatic clr_attr(input int k, input logic [31:0] d);
        bus_write(7'(k * 4 + 1), d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean_state();
        for (int k = 0; k < N_ATTR; k++) clr_attr(k, 32'hFFFF_FFFF);
        set_attr(0, 32'hFFFF_FFFF);
    endtask

    function automatic logic [31:0] exp_pad(input logic [31:0] own, psb, md, go, ge,
                                            input logic [31:0] ao, ae, bo, be, input bit want_oe);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic so, se;
            so = own[i] ? go[i] : (psb[i] ? bo[i] : ao[i]);
            se = own[i] ? ge[i] : (psb[i] ? be[i] : ae[i]);
            r[i] = want_oe ? (se && !(md[i] && so)) : (md[i] ? 1'b0 : so);
        end
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, p, q, own_m, psb_m, md_m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        bus_read(7'h02, d); check("R2 ownership reset", d, 32'hFFFF_FFFF);
        bus_read(7'h06, d); check("R2 output enable reset", d, 32'h0);
        check("R2 pad_oe reset", pad_oe, 32'h0);
        check("R2 irq reset", {31'b0, irq}, 32'h0);

        // R1: set/clear/status sweep over every attribute
        for (int k = 0; k < N_ATTR; k++) begin
            p = 32'h9E37_79B9 ^ (32'(k) * 32'h0101_0101);
            q = {p[15:0], p[31:16]} ^ 32'h0F0F_0F0F;
            set_attr(k, p);
            clr_attr(k, q);
            bus_read(7'(k * 4 + 2), d);
            check($sformatf("R1 attr %0d set/clear", k), d,
                  (((k == 0) ? 32'hFFFF_FFFF : 32'h0) | p) & ~q);
        end
        clean_state();
        bus_read(ADR_ISR, d);

        // R5: pull-up follows attribute
        set_attr(3, 32'h5A5A_C3C3);
        check("R5 pad_pullup", pad_pullup, 32'h5A5A_C3C3);
        clr_attr(3, 32'hFFFF_FFFF);

        // R3, R4: per-line source and open-drain sweep; line config = i mod 8
        own_m = '0; psb_m = '0; md_m = '0;
        for (int i = 0; i < 32; i++) begin
            own_m[i] = i[0]; psb_m[i] = i[1]; md_m[i] = i[2];
        end
        clr_attr(0, ~own_m);
        set_attr(7, psb_m);
        set_attr(4, md_m);
        for (int r = 0; r < 4; r++) begin
            logic [31:0] go, ge;
            go = 32'h3C96_A55A ^ (32'(r) * 32'h1111_1111);
            ge = 32'hF0CC_AA33 ^ (32'(r) * 32'h2468_ACE1);
            set_attr(2, go); clr_attr(2, ~go);
            set_attr(1, ge); clr_attr(1, ~ge);
            @(negedge clk);
            pa_out = 32'h0F0F_3355 + 32'(r) * 32'h0137_9BDF;
            pa_oe  = ~pa_out ^ 32'h00FF_00FF;
            pb_out = 32'h6699_A5C3 ^ (32'(r) << 3);
            pb_oe  = pb_out ^ 32'hFF00_FF00;
            #1;
            check($sformatf("R3 R4 pad_out round %0d", r), pad_out,
                  exp_pad(own_m, psb_m, md_m, go, ge, pa_out, pa_oe, pb_out, pb_oe, 1'b0));
            check($sformatf("R3 R4 pad_oe round %0d", r), pad_oe,
                  exp_pad(own_m, psb_m, md_m, go, ge, pa_out, pa_oe, pb_out, pb_oe, 1'b1));
        end

        // R6: pin levels visible while lines are owned by peripherals
        @(negedge clk); pin_in = 32'hC001_D00D;
        idle(2); bus_read(ADR_PINS, d); check("R6 pins pattern 1", d, 32'hC001_D00D);
        @(negedge clk); pin_in = 32'h1234_8765;
        idle(2); bus_read(ADR_PINS, d); check("R6 pins pattern 2", d, 32'h1234_8765);

        // R12: masked synchronous output write
        clean_state();
        set_attr(2, 32'hAAAA_AAAA);
        set_attr(12, 32'h0000_FFFF);
        bus_write(ADR_SYNC, 32'h1234_5678);
        bus_read(ADR_SYNC, d); check("R12 masked write", d, 32'hAAAA_5678);

        // R9: interrupt mode sweep on lines 0..4
        clean_state();
        @(negedge clk); pin_in = '0;
        set_attr(9, 32'h1E);          // lines 1..4 special
        set_attr(10, 32'h18);         // lines 3,4 level
        set_attr(11, 32'h0A);         // lines 1,3 polarity high
        idle(4);
        bus_read(ADR_ISR, d);
        begin
            logic v, vprev;
            vprev = 1'b0;
            for (int s = 0; s < 4; s++) begin
                logic [31:0] e_edge, e_lvl;
                v = ~s[0];
                @(negedge clk); pin_in[4:0] = {5{v}};
                idle(5);
                e_edge = 32'h1 | ((v && !vprev) ? 32'h2 : 32'h0) | ((!v && vprev) ? 32'h4 : 32'h0);
                e_lvl  = v ? 32'h8 : 32'h10;
                bus_read(ADR_ISR, d);
                check($sformatf("R9 edge modes step %0d", s), d & 32'h7, e_edge);
                bus_read(ADR_ISR, d);
                check($sformatf("R9 level modes step %0d", s), d, e_lvl);
                vprev = v;
            end
        end

        // R11: interrupt output gating (line 4 low level pending, pins low)
        set_attr(8, 32'h10); idle(1);
        check("R11 enabled pending", {31'b0, irq}, 32'h1);
        clr_attr(8, 32'h10); idle(1);
        check("R11 disabled pending", {31'b0, irq}, 32'h0);
        bus_read(ADR_ISR, d);
        set_attr(8, 32'h2); idle(1);
        check("R11 enabled not pending", {31'b0, irq}, 32'h0);
        clr_attr(8, 32'hFFFF_FFFF);

        // R10: event arriving in the read cycle survives the clear
        @(negedge clk); pin_in[1] = 1'b1;
        idle(5);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADR_ISR;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
        check("R10 read before coinciding event", d, 32'h12);
        bus_read(ADR_ISR, d);
        check("R10 coinciding event kept", d, 32'h11);
        bus_read(ADR_ISR, d);
        check("R10 cleared on read", d & ~32'h10, 32'h0);

        // R7: glitch filter on line 8, unfiltered reference on line 9
        clean_state();
        @(negedge clk); pin_in = '0;
        set_attr(5, 32'h100);
        idle(4);
        bus_read(ADR_ISR, d);
        @(negedge clk); pin_in[9:8] = 2'b11;
        @(negedge clk); pin_in[9:8] = 2'b00;
        idle(6);
        bus_read(ADR_ISR, d);
        check("R7 one-clock pulse rejected", d & 32'h100, 32'h0);
        check("R7 one-clock pulse seen unfiltered", d & 32'h200, 32'h200);
        @(negedge clk); pin_in[8] = 1'b1;
        @(negedge clk);
        @(negedge clk); pin_in[8] = 1'b0;
        idle(6);
        bus_read(ADR_ISR, d);
        check("R7 two-clock pulse passes", d & 32'h100, 32'h100);
        @(negedge clk); pin_in[8] = 1'b1;
        idle(6);
        check("R7 steady level on per_in", per_in & 32'h100, 32'h100);
        @(negedge clk); pin_in[8] = 1'b0;
        idle(6);

        // R8: debounce on line 10
        set_attr(5, 32'h400);
        set_attr(6, 32'h400);
        bus_write(ADR_DIV, 32'd3);
        bus_read(ADR_DIV, d); check("R8 divider readback", d, 32'd3);
        bus_read(ADR_ISR, d);
        @(negedge clk); pin_in[10] = 1'b1;
        idle(4);
        @(negedge clk); pin_in[10] = 1'b0;
        idle(30);
        bus_read(ADR_ISR, d);
        check("R8 short pulse rejected", d & 32'h400, 32'h0);
        @(negedge clk); pin_in[10] = 1'b1;
        idle(40);
        check("R8 long level accepted", per_in & 32'h400, 32'h400);
        @(negedge clk); pin_in[10] = 1'b0;
        idle(40);
        check("R8 release accepted", per_in & 32'h400, 32'h0);
        bus_write(ADR_DIV, 32'd0);
        bus_read(ADR_ISR, d);
        @(negedge clk); pin_in[10] = 1'b1;
        idle(4);
        @(negedge clk); pin_in[10] = 1'b0;
        idle(10);
        bus_read(ADR_ISR, d);
        check("R8 same pulse passes with fast tick", d & 32'h400, 32'h400);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule